// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block sits beside a two-wire slave interface and answers the SMBus alert response address on behalf of a device whose alert output is active. When the device runs in interrupt mode and its alert is raised, the block acknowledges the alert response byte sent by the bus master. It then returns the device's own 7-bit slave address, MSB first, with a cause bit appended as the eighth bit.

Several devices may answer at once. The block arbitrates bit by bit on the wired-AND data line. A device that loses goes silent and keeps its alert raised. A device that wins issues a one-cycle clear pulse for its alert when the transaction closes.

The block takes sampled SCL and SDA levels plus START and STOP strobes that a bus front end has already decoded. It drives SDA only through an open-drain pull-down enable.

Top module: `smb_alert_responder`

## Requirements
- R1: After a START, the block acknowledges (pulls SDA low during the ninth SCL pulse) a received byte equal to 0x19, taken MSB first on SCL rising edges, provided irq_mode_i=1 and alert_active_i=1 when the eighth bit has been received.
- R2: If the byte differs from 0x19, or irq_mode_i=0, or alert_active_i=0, the block never pulls SDA during that transaction. It also never pulls SDA while receiving the eight command bits.
- R3: After its acknowledge, the block sends eight bits MSB first: dev_addr_i[6:0], then the cause bit, which is 1 when cause_high_i=1 (high limit reached) and 0 otherwise. A 0 bit is sent by pulling SDA low. A 1 bit is sent by releasing SDA.
- R4: If the block releases SDA for a 1 bit but samples SDA low on that SCL rising edge, it has lost arbitration. It then does not pull SDA for the rest of the transaction.
- R5: The block releases SDA during the master's acknowledge bit that follows the returned byte.
- R6: If all eight returned bits and the master's acknowledge bit complete without lost arbitration, alert_clr_o pulses high for exactly one clock. The pulse comes in the cycle after the STOP or repeated START strobe that ends the transaction.
- R7: alert_clr_o stays low if arbitration was lost, or if a STOP or START arrives before the master's acknowledge bit completes.
- R8: The block asserts its SDA pull-down only while SCL is low.
- R9: While rst_ni is low, sda_pull_o and alert_clr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (wired-AND bus) |
| start_i | input | 1 | One-cycle START / repeated START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| irq_mode_i | input | 1 | 1 = interrupt mode selected |
| alert_active_i | input | 1 | Device alert output currently asserted |
| cause_high_i | input | 1 | 1 = high limit reached, 0 = below low limit |
| dev_addr_i | input | 7 | Device 7-bit slave address |
| sda_pull_o | output | 1 | Open-drain SDA pull-down enable |
| alert_clr_o | output | 1 | One-cycle alert clear pulse |

## Verification
The bench places a behavioural competing responder on the wired-AND line. It covers three outcomes: the block loses mid-address, the block wins, and the two addresses tie so the cause bit decides. A responder that kept driving after losing would corrupt the competitor's bits. One that ignored arbitration would clear its alert as a loser. The bench also checks that the gating inputs and a write-direction command byte each suppress the acknowledge. It checks that the master's acknowledge bit is left free. It checks that a STOP in mid-address, or a repeated START after a win, clears the alert correctly or not at all.

// File: rtl/smb_ar_pkg.sv
package smb_ar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_DONE,
    ST_SKIP
  } ar_state_e;
endpackage

// File: rtl/smb_ar_edge.sv
module smb_ar_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/smb_ar_shift.sv
module smb_ar_shift #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         sample_i,
  input  logic         rx_mode_i,
  input  logic         sda_i,
  input  logic         adv_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic [W-1:0]  sreg_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= load_val_i;
      cnt_q  <= '0;
    end else if (sample_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (rx_mode_i) sreg_q <= {sreg_q[W-2:0], sda_i};
    end else if (adv_i) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
    end
  end

  assign data_o = sreg_q;
  assign full_o = (cnt_q == CW'(W));
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int         ADDR_W   = 7,
  parameter logic [7:0] ARA_BYTE = 8'h19,
  localparam int        BYTE_W   = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              irq_mode_i,
  input  logic              alert_active_i,
  input  logic              cause_high_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              sda_pull_o,
  output logic              alert_clr_o
);
  import smb_ar_pkg::*;

  ar_state_e   state_q, state_d;
  logic        pull_q, pull_d;
  logic        lost_q, lost_d;
  logic        clr_q, clr_d;
  logic        scl_rise, scl_fall;
  logic        sh_clr, sh_load, sh_sample, sh_adv;
  logic [BYTE_W-1:0] sh_data, tx_word;
  logic        sh_full, rx_phase, hit;

  smb_ar_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  smb_ar_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (sh_clr),
    .load_i     (sh_load),
    .load_val_i (tx_word),
    .sample_i   (sh_sample),
    .rx_mode_i  (rx_phase),
    .sda_i      (sda_i),
    .adv_i      (sh_adv),
    .data_o     (sh_data),
    .full_o     (sh_full)
  );

  assign rx_phase = (state_q == ST_RX);
  assign tx_word  = {dev_addr_i, cause_high_i};
  assign hit      = (sh_data == BYTE_W'(ARA_BYTE)) & irq_mode_i & alert_active_i;

  always_comb begin
    state_d   = state_q;
    pull_d    = pull_q;
    lost_d    = lost_q;
    clr_d     = 1'b0;
    sh_clr    = 1'b0;
    sh_load   = 1'b0;
    sh_sample = 1'b0;
    sh_adv    = 1'b0;
    if (stop_i || start_i) begin
      // transaction boundary: a completed win releases the alert
      clr_d   = (state_q == ST_DONE);
      state_d = stop_i ? ST_IDLE : ST_RX;
      pull_d  = 1'b0;
      lost_d  = 1'b0;
      sh_clr  = 1'b1;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_sample = 1'b1;
          end else if (scl_fall && sh_full) begin
            sh_clr = 1'b1;
            if (hit) begin
              state_d = ST_ACK;
              pull_d  = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d = ST_TX;
            sh_load = 1'b1;
            pull_d  = ~tx_word[BYTE_W-1];
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            sh_sample = 1'b1;
            if (sh_data[BYTE_W-1] && !sda_i) lost_d = 1'b1;
          end else if (scl_fall) begin
            if (sh_full) begin
              state_d = ST_MACK;
              pull_d  = 1'b0;
            end else begin
              sh_adv = 1'b1;
              pull_d = ~sh_data[BYTE_W-2] & ~lost_q;
            end
          end
        end
        ST_MACK: begin
          if (scl_fall) state_d = lost_q ? ST_SKIP : ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
      lost_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pull_q  <= pull_d;
      lost_q  <= lost_d;
      clr_q   <= clr_d;
    end
  end

  assign sda_pull_o  = pull_q;
  assign alert_clr_o = clr_q;
endmodule

// File: rtl/smb_ar_checker.sv
module smb_ar_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic start_i,
  input logic stop_i,
  input logic sda_pull_o,
  input logic alert_clr_o,
  input logic lost_i,
  input logic rx_phase_i
);
  p_pull_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !$past(scl_i));

  p_lost_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |-> !sda_pull_o);

  p_rx_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_phase_i |-> !sda_pull_o);

  p_clr_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_clr_o |=> !alert_clr_o);

  p_clr_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_clr_o |-> $past(start_i || stop_i));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r9: assert (!sda_pull_o && !alert_clr_o);
    end
  end
endmodule

bind smb_alert_responder smb_ar_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .sda_pull_o  (sda_pull_o),
  .alert_clr_o (alert_clr_o),
  .lost_i      (lost_q),
  .rx_phase_i  (rx_phase)
);

// File: tb/smb_alert_responder_bench.sv
module smb_alert_responder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, o_sda = 1'b1;
  logic start_s = 1'b0, stop_s = 1'b0;
  logic irq_mode = 1'b1, alert_on = 1'b1, cause_hi = 1'b1;
  logic [6:0] addr = 7'h49;
  logic pull, clr;
  logic sda_bus;
  int total = 0, bad = 0, clr_cnt = 0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & o_sda & ~pull;

  smb_alert_responder u_smb_alert_responder (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .start_i(start_s), .stop_i(stop_s), .irq_mode_i(irq_mode),
    .alert_active_i(alert_on), .cause_high_i(cause_hi), .dev_addr_i(addr),
    .sda_pull_o(pull), .alert_clr_o(clr)
  );

  always @(posedge clk) if (clr) clr_cnt <= clr_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); m_sda = 1'b1; o_sda = 1'b1;
    wait_clk(2); scl = 1'b1; wait_clk(3);
    m_sda = 1'b0; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    wait_clk(3); scl = 1'b0; wait_clk(1);
  endtask

  task automatic do_stop();
    @(negedge clk); scl = 1'b0; m_sda = 1'b0; o_sda = 1'b1;
    wait_clk(3); scl = 1'b1; wait_clk(3);
    m_sda = 1'b1; stop_s = 1'b1;
    @(negedge clk); stop_s = 1'b0;
    wait_clk(3);
  endtask

  // one SCL period; returns bus level and our pull during the high phase
  task automatic bit_cyc(input logic mb, input logic ob, output logic seen, output logic pl);
    @(negedge clk); scl = 1'b0; m_sda = mb; o_sda = ob;
    wait_clk(4); scl = 1'b1;
    wait_clk(3); seen = sda_bus; pl = pull;
    wait_clk(1); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_seen, output int pulls);
    logic s, p;
    pulls = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(b[i], 1'b1, s, p);
      if (p) pulls++;
    end
    bit_cyc(1'b1, 1'b1, ack_seen, p);
  endtask

  // read returned byte; competitor (if present) arbitrates honestly
  task automatic read_byte(input logic comp_en, input logic [7:0] cb,
                           output logic [7:0] got, output logic mack_pull);
    logic s, p, c_lost;
    c_lost = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1, (comp_en && !c_lost) ? cb[i] : 1'b1, s, p);
      got[i] = s;
      if (comp_en && cb[i] && !s) c_lost = 1'b1;
    end
    bit_cyc(1'b1, 1'b1, s, mack_pull);
  endtask

  task automatic ara_txn(input string req, input logic comp_en, input logic [7:0] cb,
                         input logic [7:0] exp_byte, input int exp_clr);
    logic ack, mp; logic [7:0] got; int pulls, c0;
    c0 = clr_cnt;
    do_start();
    send_byte(8'h19, ack, pulls);
    chk({req, " R1 ack"}, ack, 0);
    chk({req, " R2 no pull on cmd bits"}, pulls, 0);
    read_byte(comp_en, cb, got, mp);
    chk({req, " R3/R4 returned byte"}, got, exp_byte);
    chk({req, " R5 master ack free"}, mp, 0);
    do_stop();
    chk({req, " R6/R7 clear count"}, clr_cnt - c0, exp_clr);
  endtask

  task automatic no_resp(input string req, input logic [7:0] cmd);
    logic ack, mp; logic [7:0] got; int pulls, c0;
    c0 = clr_cnt;
    do_start();
    send_byte(cmd, ack, pulls);
    chk({req, " R2 no ack"}, ack, 1);
    read_byte(1'b0, 8'hFF, got, mp);
    chk({req, " R2 bus stays high"}, got, 8'hFF);
    chk({req, " R2 no pull"}, pulls, 0);
    do_stop();
    chk({req, " R7 no clear"}, clr_cnt - c0, 0);
  endtask

  task automatic t_reset();
    chk("R9 pull in reset", pull, 0);
    chk("R9 clear in reset", clr, 0);
    wait_clk(2); rst_n = 1'b1; wait_clk(2);
    chk("R9 pull after reset", pull, 0);
  endtask

  task automatic t_win_high();  cause_hi = 1'b1; ara_txn("win high R6", 1'b0, 8'hFF, 8'h93, 1); endtask
  task automatic t_win_low();   cause_hi = 1'b0; ara_txn("win low R3", 1'b0, 8'hFF, 8'h92, 1); cause_hi = 1'b1; endtask
  task automatic t_lose();      ara_txn("lose R4", 1'b1, 8'h85, 8'h85, 0); endtask
  task automatic t_beat();      ara_txn("beat R6", 1'b1, 8'h98, 8'h93, 1); endtask
  task automatic t_tie_cause(); ara_txn("tie cause R4", 1'b1, 8'h92, 8'h92, 0); endtask
  task automatic t_mode_off();  irq_mode = 1'b0; no_resp("mode off R2", 8'h19); irq_mode = 1'b1; endtask
  task automatic t_alert_off(); alert_on = 1'b0; no_resp("alert off R2", 8'h19); alert_on = 1'b1; endtask
  task automatic t_wrong_cmd(); no_resp("write dir R2", 8'h18); endtask

  task automatic t_abort();
    logic ack, s, p; int pulls, c0;
    c0 = clr_cnt;
    do_start();
    send_byte(8'h19, ack, pulls);
    chk("abort R1 ack", ack, 0);
    for (int i = 0; i < 3; i++) bit_cyc(1'b1, 1'b1, s, p);
    do_stop();
    chk("abort R7 no clear", clr_cnt - c0, 0);
    chk("abort R7 pull released", pull, 0);
  endtask

  task automatic t_rep_start();
    logic ack, mp; logic [7:0] got; int pulls, c0;
    c0 = clr_cnt;
    do_start();
    send_byte(8'h19, ack, pulls);
    read_byte(1'b0, 8'hFF, got, mp);
    chk("rep start R3 byte", got, 8'h93);
    do_start();
    wait_clk(2);
    chk("rep start R6 clear on Sr", clr_cnt - c0, 1);
    do_stop();
    chk("rep start R6 single pulse", clr_cnt - c0, 1);
  endtask

  initial begin
    t_reset();
    t_win_high();
    t_win_low();
    t_lose();
    t_beat();
    t_tie_cause();
    t_mode_off();
    t_alert_off();
    t_wrong_cmd();
    t_abort();
    t_rep_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule